// File: doc/BRIEF.md
# Bank Row Tracking Command Decoder

This block sits between a user command port and the command side of a DRAM controller. It takes one user command at a time through a ready/valid handshake. It splits the address into row, bank and column fields. It then turns each access into the shortest legal series of memory commands. For each of the four banks it records whether a row is open and which row that is. An access to the open row therefore costs one column command. An access to a closed bank costs an ACTIVE and then the column command. An access to a different row costs a PRECHARGE, an ACTIVE and the column command.

The block holds one command at a time. It raises ready in the same cycle that the last memory command of the current user command goes out, so the next user command is decoded while the current one is still being issued. Commands that are not accesses (mode load, self refresh, power down and the related exits) close every open bank with a single precharge-all. After that they pass through as one command that carries the user code. Per-bank and global down-counters hold back any command that would break the minimum spacing between memory commands.

Top module: `bank_cmd_decoder`

## Requirements
- R1: A user command is taken on a rising edge where `cmd_rdy` and `cmd_valid` are both high. `cmd_rdy` does not depend on `cmd_valid`. A command that is held waiting is issued unchanged and in order.
- R2: `cmd_addr` is split, from MSB to LSB, into row (ROW_W bits), bank (2 bits) and column (COL_W bits). The fields appear unchanged on `mem_row`, `mem_bank` and `mem_col`.
- R3: An access to a bank with no open row issues ACTIVE (`mem_op`=1) and then the column command: READ `mem_op`=4 or WRITE `mem_op`=5.
- R4: An access to the row already open in its bank issues only the column command.
- R5: An access to a bank that has a different row open issues PRECHARGE (`mem_op`=2), then ACTIVE, then the column command.
- R6: User codes 0011 (read) and 0100 (write) issue the column command with `mem_ap`=1 and leave the bank closed. Codes 0001 (read) and 0010 (write) use `mem_ap`=0 and leave the row open.
- R7: Valid codes 0101 to 1100 are non-access commands. If any bank is open, each of them first issues precharge-all (`mem_op`=3). It then issues pass-through (`mem_op`=6) with the user code on `mem_code`, and leaves every bank closed.
- R8: Codes 0000, 1101, 1110 and 1111 are accepted and dropped. They issue nothing and leave the bank state unchanged.
- R9: Minimum spacing in clocks: ACTIVE to column T_RCD. Precharge (explicit or auto) to ACTIVE T_RP. ACTIVE to ACTIVE in a bank T_RC. ACTIVE to precharge T_RAS. WRITE to precharge T_WR, with an auto-precharge after a write taking effect T_WR after the WRITE. WRITE to READ T_WTR.
- R10: After reset all banks are closed, `cmd_rdy` is high and `mem_valid` is low.
- R11: `cmd_rdy` is high in the cycle that the last memory command of the held command issues. Back-to-back reads to an open row therefore issue on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | User command valid |
| cmd_code | input | 4 | User command code |
| cmd_addr | input | ROW_W+2+COL_W | User address: row, bank, column |
| cmd_rdy | output | 1 | Ready to take a user command |
| mem_valid | output | 1 | A memory command issues this cycle |
| mem_op | output | 3 | Memory command: 1 ACT, 2 PRE, 3 PREA, 4 RD, 5 WR, 6 pass-through |
| mem_bank | output | 2 | Target bank |
| mem_row | output | ROW_W | Row address |
| mem_col | output | COL_W | Column address |
| mem_ap | output | 1 | Auto-precharge on a column command |
| mem_code | output | 4 | User code carried by a pass-through |

## Verification
The bench targets the three page outcomes, which are hit, miss and closed bank, including a bank closed by auto-precharge. A decoder that lost the row tags would insert needless ACTIVEs or skip a required PRECHARGE, and the expected command stream would no longer match. Invalid codes are sent between accesses and are followed by a hit to a bank left open. A decoder that acted on them would emit a command or lose the hit. The bench also measures the gaps between issued commands against every spacing rule. It requires consecutive hits one clock apart, which catches a ready that waits a cycle too long. The extreme address fields catch a mis-sliced address.

// File: rtl/bank_cmd_decoder.sv
module bank_cmd_decoder #(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int T_RC  = 10,
  parameter int T_RAS = 6,
  parameter int T_WR  = 2,
  parameter int T_WTR = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [3:0]               cmd_code,
  input  logic [ROW_W+2+COL_W-1:0] cmd_addr,
  output logic                     cmd_rdy,
  output logic                     mem_valid,
  output logic [2:0]               mem_op,
  output logic [1:0]               mem_bank,
  output logic [ROW_W-1:0]         mem_row,
  output logic [COL_W-1:0]         mem_col,
  output logic                     mem_ap,
  output logic [3:0]               mem_code
);
  localparam int AW = ROW_W + 2 + COL_W;
  localparam int NB = 4;
  localparam int CW = $clog2(T_RC + T_RP + T_WR + 1) + 1;
  localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_RPW = CW'(T_RP + T_WR - 1);
  localparam logic [CW-1:0] L_WR  = CW'(T_WR - 1);
  localparam logic [CW-1:0] L_WTR = CW'(T_WTR - 1);
  localparam logic [2:0] OP_NOP = 3'd0, OP_ACT = 3'd1, OP_PRE = 3'd2, OP_PREA = 3'd3,
                         OP_RD = 3'd4, OP_WR = 3'd5, OP_PASS = 3'd6;

  logic              pend_vld;
  logic [3:0]        pend_code;
  logic [AW-1:0]     pend_addr;
  logic [NB-1:0]     open_q;
  logic [ROW_W-1:0]  orow_q [NB];
  logic [CW-1:0]     rcd_q [NB], ras_q [NB], rc_q [NB], rp_q [NB], wr_q [NB];
  logic [CW-1:0]     wtr_q;

  logic [ROW_W-1:0]  p_row;
  logic [1:0]        p_bank;
  logic [COL_W-1:0]  p_col;
  logic              is_acc, is_wr, is_ap, hit, prea_ok, pass_ok, done, in_ok;
  logic [2:0]        op;

  assign p_row  = pend_addr[AW-1 -: ROW_W];
  assign p_bank = pend_addr[COL_W +: 2];
  assign p_col  = pend_addr[COL_W-1:0];
  assign is_acc = pend_code >= 4'd1 && pend_code <= 4'd4;
  assign is_wr  = pend_code == 4'd2 || pend_code == 4'd4;
  assign is_ap  = pend_code == 4'd3 || pend_code == 4'd4;
  assign hit    = open_q[p_bank] && orow_q[p_bank] == p_row;
  assign in_ok  = cmd_code >= 4'd1 && cmd_code <= 4'd12;

  always_comb begin
    prea_ok = 1'b1;
    pass_ok = 1'b1;
    for (int b = 0; b < NB; b++) begin
      if (open_q[b] && (ras_q[b] != '0 || wr_q[b] != '0)) prea_ok = 1'b0;
      if (rp_q[b] != '0) pass_ok = 1'b0;
    end
  end

  always_comb begin
    op   = OP_NOP;
    done = 1'b0;
    if (pend_vld) begin
      if (is_acc) begin
        if (hit) begin
          if (rcd_q[p_bank] == '0 && (is_wr || wtr_q == '0) && (!is_ap || ras_q[p_bank] == '0)) begin
            op   = is_wr ? OP_WR : OP_RD;
            done = 1'b1;
          end
        end else if (open_q[p_bank]) begin
          if (ras_q[p_bank] == '0 && wr_q[p_bank] == '0) op = OP_PRE;
        end else if (rp_q[p_bank] == '0 && rc_q[p_bank] == '0) begin
          op = OP_ACT;
        end
      end else if (|open_q) begin
        if (prea_ok) op = OP_PREA;
      end else if (pass_ok) begin
        op   = OP_PASS;
        done = 1'b1;
      end
    end
  end

  assign cmd_rdy   = !pend_vld || done;
  assign mem_valid = op != OP_NOP;
  assign mem_op    = op;
  assign mem_bank  = p_bank;
  assign mem_row   = p_row;
  assign mem_col   = p_col;
  assign mem_ap    = is_ap && (op == OP_RD || op == OP_WR);
  assign mem_code  = pend_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_code <= '0;
      pend_addr <= '0;
    end else begin
      if (done) pend_vld <= 1'b0;
      if (cmd_rdy && cmd_valid && in_ok) begin
        pend_vld  <= 1'b1;
        pend_code <= cmd_code;
        pend_addr <= cmd_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= '0;
      wtr_q  <= '0;
      for (int b = 0; b < NB; b++) begin
        orow_q[b] <= '0;
        rcd_q[b]  <= '0;
        ras_q[b]  <= '0;
        rc_q[b]   <= '0;
        rp_q[b]   <= '0;
        wr_q[b]   <= '0;
      end
    end else begin
      if (wtr_q != '0) wtr_q <= wtr_q - 1'b1;
      if (op == OP_WR) wtr_q <= L_WTR;
      for (int b = 0; b < NB; b++) begin
        if (rcd_q[b] != '0) rcd_q[b] <= rcd_q[b] - 1'b1;
        if (ras_q[b] != '0) ras_q[b] <= ras_q[b] - 1'b1;
        if (rc_q[b]  != '0) rc_q[b]  <= rc_q[b]  - 1'b1;
        if (rp_q[b]  != '0) rp_q[b]  <= rp_q[b]  - 1'b1;
        if (wr_q[b]  != '0) wr_q[b]  <= wr_q[b]  - 1'b1;
        if (op == OP_ACT && p_bank == 2'(b)) begin
          open_q[b] <= 1'b1;
          orow_q[b] <= p_row;
          rcd_q[b]  <= L_RCD;
          ras_q[b]  <= L_RAS;
          rc_q[b]   <= L_RC;
        end
        if ((op == OP_PRE && p_bank == 2'(b)) || (op == OP_PREA && open_q[b])) begin
          open_q[b] <= 1'b0;
          rp_q[b]   <= L_RP;
        end
        if ((op == OP_RD || op == OP_WR) && p_bank == 2'(b)) begin
          if (is_wr) wr_q[b] <= L_WR;
          if (is_ap) begin
            open_q[b] <= 1'b0;
            rp_q[b]   <= is_wr ? L_RPW : L_RP;
          end
        end
      end
    end
  end

  a_r1_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld && !done |=> pend_vld && $stable(pend_code) && $stable(pend_addr));
  a_r3_act_only_closed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_op == OP_ACT |-> !open_q[mem_bank]);
  a_r4_col_on_open_row: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && (mem_op == OP_RD || mem_op == OP_WR) |-> open_q[mem_bank] && orow_q[mem_bank] == mem_row);
  a_r5_pre_only_open: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_op == OP_PRE |-> open_q[mem_bank]);
  a_r6_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ap |=> !open_q[$past(mem_bank)]);
  a_r7_pass_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_op == OP_PASS |-> open_q == '0);
endmodule

// File: tb/tb_bank_cmd_decoder.sv
module tb_bank_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13, COL_W = 10, AW = ROW_W + 2 + COL_W;
  localparam int T_RCD = 3, T_RP = 3, T_RC = 10, T_RAS = 6, T_WR = 2, T_WTR = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_code = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_rdy, mem_valid, mem_ap;
  logic [2:0] mem_op;
  logic [1:0] mem_bank;
  logic [ROW_W-1:0] mem_row;
  logic [COL_W-1:0] mem_col;
  logic [3:0] mem_code;

  bank_cmd_decoder #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RC(T_RC),
    .T_RAS(T_RAS), .T_WR(T_WR), .T_WTR(T_WTR)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .cmd_rdy(cmd_rdy), .mem_valid(mem_valid), .mem_op(mem_op), .mem_bank(mem_bank),
    .mem_row(mem_row), .mem_col(mem_col), .mem_ap(mem_ap), .mem_code(mem_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [2:0] op; logic [1:0] bank; logic [ROW_W-1:0] row; logic [COL_W-1:0] col;
    logic ap; logic [3:0] code; int gap; string req;
  } exp_t;
  exp_t exp_q[$];

  int ntest = 0, nfail = 0, cyc = 0;
  bit finished = 0;
  bit m_open [4];
  logic [ROW_W-1:0] m_row [4];
  bit s_open [4];
  int last_act [4], last_pre [4], last_wr [4];
  int last_wr_any = -1000, last_any = -1000;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] op, input int b, input int r, input int c,
                      input logic ap, input logic [3:0] code, input int gap, input string req);
    exp_t e;
    e.op = op; e.bank = 2'(b); e.row = ROW_W'(r); e.col = COL_W'(c);
    e.ap = ap; e.code = code; e.gap = gap; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic send(input logic [3:0] code, input int r, input int b, input int c, input int gap);
    bit any;
    if (code >= 1 && code <= 4) begin
      logic [2:0] cop;
      logic ap;
      cop = (code == 2 || code == 4) ? 3'd5 : 3'd4;
      ap  = (code == 3 || code == 4);
      if (m_open[b] && m_row[b] == ROW_W'(r)) begin
        push(cop, b, r, c, ap, code, gap, "R4 page hit");
      end else if (m_open[b]) begin
        push(3'd2, b, r, c, 1'b0, code, -1, "R5 miss precharge");
        push(3'd1, b, r, c, 1'b0, code, -1, "R5 miss activate");
        push(cop, b, r, c, ap, code, gap, "R5 miss column");
      end else begin
        push(3'd1, b, r, c, 1'b0, code, -1, "R3 closed activate");
        push(cop, b, r, c, ap, code, gap, ap ? "R6 auto-precharge column" : "R3 closed column");
      end
      m_open[b] = !ap;
      m_row[b]  = ROW_W'(r);
    end else if (code >= 5 && code <= 12) begin
      any = 0;
      for (int k = 0; k < 4; k++) any |= m_open[k];
      if (any) push(3'd3, 0, 0, 0, 1'b0, code, -1, "R7 precharge all");
      push(3'd6, 0, 0, 0, 1'b0, code, -1, "R7 pass-through");
      for (int k = 0; k < 4; k++) m_open[k] = 0;
    end
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_addr  = {ROW_W'(r), 2'(b), COL_W'(c)};
    while (!cmd_rdy) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && mem_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected command", int'(mem_op), 0);
      end else begin
        exp_t e;
        int b;
        e = exp_q.pop_front();
        b = int'(mem_bank);
        chk(mem_op == e.op, e.req, int'(mem_op), int'(e.op));
        if (e.op == 3'd6) chk(mem_code == e.code, "R7 pass-through code", int'(mem_code), int'(e.code));
        if (e.op != 3'd3 && e.op != 3'd6) begin
          chk(mem_bank == e.bank && mem_row == e.row && mem_col == e.col, "R2 address fields",
              int'({mem_bank, mem_row, mem_col}), int'({e.bank, e.row, e.col}));
        end
        if (e.op == 3'd4 || e.op == 3'd5) chk(mem_ap == e.ap, "R6 auto-precharge flag", int'(mem_ap), int'(e.ap));
        if (e.gap >= 0) chk(cyc - last_any == e.gap, "R11 back-to-back issue", cyc - last_any, e.gap);
        case (mem_op)
          3'd1: begin
            chk(cyc - last_act[b] >= T_RC, "R9 ACT to ACT", cyc - last_act[b], T_RC);
            chk(cyc - last_pre[b] >= T_RP, "R9 PRE to ACT", cyc - last_pre[b], T_RP);
            last_act[b] = cyc; s_open[b] = 1;
          end
          3'd2: begin
            chk(cyc - last_act[b] >= T_RAS, "R9 ACT to PRE", cyc - last_act[b], T_RAS);
            chk(cyc - last_wr[b] >= T_WR, "R9 WR to PRE", cyc - last_wr[b], T_WR);
            last_pre[b] = cyc; s_open[b] = 0;
          end
          3'd3: begin
            for (int k = 0; k < 4; k++) if (s_open[k]) begin
              chk(cyc - last_act[k] >= T_RAS, "R9 ACT to PREA", cyc - last_act[k], T_RAS);
              chk(cyc - last_wr[k] >= T_WR, "R9 WR to PREA", cyc - last_wr[k], T_WR);
              last_pre[k] = cyc; s_open[k] = 0;
            end
          end
          3'd4, 3'd5: begin
            chk(cyc - last_act[b] >= T_RCD, "R9 ACT to column", cyc - last_act[b], T_RCD);
            if (mem_op == 3'd4) chk(cyc - last_wr_any >= T_WTR, "R9 WR to RD", cyc - last_wr_any, T_WTR);
            if (mem_ap) begin
              chk(cyc - last_act[b] >= T_RAS, "R9 ACT to auto-precharge", cyc - last_act[b], T_RAS);
              last_pre[b] = cyc + ((mem_op == 3'd5) ? T_WR : 0);
              s_open[b] = 0;
            end
            if (mem_op == 3'd5) begin last_wr[b] = cyc; last_wr_any = cyc; end
          end
          default: ;
        endcase
        last_any = cyc;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nfail++;
      ntest++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_open[k] = 0; s_open[k] = 0; m_row[k] = '0;
      last_act[k] = -1000; last_pre[k] = -1000; last_wr[k] = -1000;
    end
    repeat (3) @(negedge clk);
    chk(cmd_rdy == 1'b1, "R10 ready after reset", int'(cmd_rdy), 1);
    chk(mem_valid == 1'b0, "R10 idle after reset", int'(mem_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_rdy == 1'b1 && mem_valid == 1'b0, "R10 idle after release", int'({cmd_rdy, mem_valid}), 2);

    send(4'd1, 5, 0, 1, -1);
    send(4'd1, 5, 0, 2, 1);
    send(4'd1, 5, 0, 3, 1);
    send(4'd2, 9, 0, 4, -1);
    send(4'd1, 9, 0, 5, -1);
    send(4'd3, 7, 1, 6, -1);
    send(4'd1, 7, 1, 7, -1);
    send(4'd4, 7, 1, 8, -1);
    send(4'd2, 1, 2, 0, -1);
    send(4'd0, 2, 2, 0, -1);
    send(4'd13, 3, 2, 0, -1);
    send(4'd15, 4, 2, 0, -1);
    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0 && cmd_rdy, "R8 invalid codes dropped", exp_q.size(), 0);
    send(4'd1, 1, 2, 9, -1);
    send(4'd6, 0, 0, 0, -1);
    send(4'd8, 0, 0, 0, -1);
    send(4'd1, (1 << ROW_W) - 1, 3, (1 << COL_W) - 1, -1);
    send(4'd2, 0, 3, 0, -1);
    send(4'd2, 0, 3, 1, -1);
    send(4'd5, 0, 0, 0, -1);
    send(4'd12, 0, 0, 0, -1);
    send(4'd2, 6, 1, 2, -1);

    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all commands issued", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule